// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the timing for an 8-bit controller's external memory bus. It runs on the oscillator clock and divides it into machine cycles of twelve clocks. In each machine cycle it drives the address-latch strobe, the active-low program-read strobe, the active-low data read and write strobes, a multiplexed low port carrying address and then data, and a high port carrying either the upper address byte or the value of the port's own output register.

The core hands over one request per machine cycle. The request is sampled on the clock edge that ends the current cycle. A code-fetch cycle performs two fetches: one at the requested address and one at the next address. A data cycle performs one external read or write, with either a 16-bit pointer or an 8-bit pointer. During a data cycle the second address-latch pulse and both program-read pulses are withheld, and the read or write strobe takes their place. Captured bytes from the low port are returned on a one-clock valid pulse.

Top module: `xbus_strobe_seq`

## Requirements
- R1: While `rst_n` is low, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `p0_out`=00H, `p2_out`=00H, `rd_valid`=0. After release, the first machine cycle is a code fetch at 0000H.
- R2: A machine cycle has twelve clock phases, numbered p0..p11, starting with p0 after reset release. `cyc_last` is high exactly in p11. The request inputs sampled on the edge that ends p11 control the following cycle.
- R3: `ale` is high in p0 and p1 of every cycle, and also in p6 and p7 of a fetch cycle. It is low at all other times. A run of fetch cycles therefore gives two pulses per twelve clocks, and a data cycle gives one.
- R4: In a fetch cycle, `psen_n` is low in p3..p5 and p9..p11. The first half (p0..p5) uses address A and the second half (p6..p11) uses A+1 modulo 65536, so FFFFH is followed by 0000H.
- R5: In a data cycle, `psen_n` stays high for all twelve phases. `rd_n` (read) or `wr_n` (write) is low in p3..p11, and the other strobe stays high.
- R6: `p0_oe`=1 and `p0_out` carries the low address byte in p0..p2, and in p6..p8 of a fetch cycle. In a write cycle, `p0_oe`=1 and `p0_out` carries the write byte in p3..p11. At all other times `p0_oe`=0 and `p0_out`=00H.
- R7: In fetch cycles, `p2_out` carries the high byte of the current half's address. In 8-bit-pointer data cycles, `p2_out` follows the `p2_latch` input combinationally through all twelve phases.
- R8: `p0_in` is captured on the edge that ends p5 and on the edge that ends p11 of a fetch cycle, and on the edge that ends p11 of a read cycle. `rd_data` shows the captured byte, and `rd_valid` is high for one clock, in the following phase.
- R9: `req_kind` encoding: 0 = fetch, 1 = read with 16-bit pointer, 2 = write with 16-bit pointer, 3 = read with 8-bit pointer, 4 = write with 8-bit pointer. Codes 5..7 behave exactly as 0.
- R10: A data cycle uses the requested address unchanged. The low byte goes on `p0_out` in p0..p2. With a 16-bit pointer, the high byte goes on `p2_out` for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 3 | Access type for the next machine cycle |
| req_addr | input | 16 | Code or data address for the next cycle |
| req_wdata | input | 8 | Write byte for the next cycle |
| p2_latch | input | 8 | Current value of the high port's output register |
| p0_in | input | 8 | Byte read back from the low port pads |
| cyc_last | output | 1 | High in the final phase of a machine cycle |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| rd_n | output | 1 | Data-read strobe, active low |
| wr_n | output | 1 | Data-write strobe, active low |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 1 | Low port drive enable |
| p2_out | output | 8 | High port drive value |
| rd_data | output | 8 | Last byte captured from the low port |
| rd_valid | output | 1 | One-clock pulse marking a new capture |

## Verification
The assertions assume that `rst_n` is released between clock edges and stays high afterwards. They also assume that the request inputs only matter at the p11 edge, so they place no constraint on those inputs at other times. The stimulus follows these rules. It releases reset on a falling edge and changes requests only on the falling edge inside p11. It changes `p0_in` and `p2_latch` on every falling edge, so the bench can see whether the data capture happens at the wrong edge and whether `p2_out` follows its input live. The request list covers all eight kind codes and an address that wraps from FFFFH.

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-DW-1:0] p2_latch,
  input  logic [DW-1:0] p0_in,
  output logic          cyc_last,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [AW-DW-1:0] p2_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int HW = AW - DW;
  localparam logic [3:0] HALF = 4'd6;
  localparam logic [3:0] LAST = 4'd11;
  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_RD16  = 3'd1;
  localparam logic [2:0] K_WR16  = 3'd2;
  localparam logic [2:0] K_RD8   = 3'd3;
  localparam logic [2:0] K_WR8   = 3'd4;

  logic [3:0]    ph;
  logic [2:0]    kind;
  logic [AW-1:0] base;
  logic [DW-1:0] wdat;
  logic [DW-1:0] rdat;
  logic          rvld;

  logic          second;
  logic [3:0]    t;
  logic          is_data, is_wr, is_rd, is_8;
  logic [AW-1:0] cur_addr;
  logic          addr_win, strb_win, cap;

  assign second   = (ph >= HALF);
  assign t        = second ? ph - HALF : ph;
  assign is_data  = (kind != K_FETCH);
  assign is_wr    = (kind == K_WR16) || (kind == K_WR8);
  assign is_rd    = (kind == K_RD16) || (kind == K_RD8);
  assign is_8     = (kind == K_RD8) || (kind == K_WR8);
  assign cur_addr = (second && !is_data) ? base + {{(AW-1){1'b0}}, 1'b1} : base;

  assign addr_win = rst_n && (t < 4'd3) && !(is_data && second);
  assign strb_win = rst_n && is_data && (ph >= 4'd3);

  assign cyc_last = rst_n && (ph == LAST);
  assign ale      = rst_n && (t < 4'd2) && !(is_data && second);
  assign psen_n   = !(rst_n && !is_data && (t >= 4'd3));
  assign rd_n     = !(strb_win && !is_wr);
  assign wr_n     = !(strb_win && is_wr);
  assign p0_oe    = addr_win || (strb_win && is_wr);
  assign p0_out   = addr_win ? cur_addr[DW-1:0] :
                    (strb_win && is_wr) ? wdat : '0;
  assign p2_out   = !rst_n ? '0 :
                    (is_data && is_8) ? p2_latch : cur_addr[AW-1:DW];
  assign rd_data  = rdat;
  assign rd_valid = rvld;

  assign cap = (!is_data && (ph == 4'd5 || ph == LAST)) || (is_rd && ph == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      kind <= K_FETCH;
      base <= '0;
      wdat <= '0;
      rdat <= '0;
      rvld <= 1'b0;
    end else begin
      rvld <= cap;
      if (cap) rdat <= p0_in;
      if (ph == LAST) begin
        ph   <= '0;
        kind <= (req_kind > K_WR8) ? K_FETCH : req_kind;
        base <= req_addr;
        wdat <= req_wdata;
      end else begin
        ph <= ph + 4'd1;
      end
    end
  end

  a_r3_ale_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n))
    else $error("ale overlaps a read or write strobe");

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~psen_n, ~rd_n, ~wr_n}))
    else $error("more than one bus strobe active");

  a_r4_psen_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> $past(!ale))
    else $error("program strobe fell while ale was high");

  a_r6_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe)
    else $error("low port driven during a read strobe");

  a_r6_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe)
    else $error("low port not driven during write strobe");

  a_r2_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> ale)
    else $error("new machine cycle did not open with ale");

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!psen_n || !rd_n))
    else $error("capture pulse without a preceding read strobe");

  localparam int UNUSED_HW = HW;
endmodule

// File: tb/xbus_strobe_seq_tb.sv
module xbus_strobe_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0000;
  logic [7:0]  req_wdata = 8'h00;
  logic [7:0]  p2_latch = 8'h00;
  logic [7:0]  p0_in = 8'h00;
  logic        cyc_last, ale, psen_n, rd_n, wr_n, p0_oe, rd_valid;
  logic [7:0]  p0_out, p2_out, rd_data;

  xbus_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .p2_latch(p2_latch), .p0_in(p0_in),
    .cyc_last(cyc_last), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_fetch(int k); return (k == 0) || (k >= 5); endfunction
  function automatic bit is_rd(int k);    return (k == 1) || (k == 3); endfunction
  function automatic bit is_wr(int k);    return (k == 2) || (k == 4); endfunction
  function automatic bit is_8(int k);     return (k == 3) || (k == 4); endfunction

  int kinds [16] = '{0, 0, 1, 2, 3, 4, 0, 5, 1, 6, 2, 7, 3, 4, 0, 0};
  int addrs [16] = '{16'h1234, 16'h00FF, 16'h8001, 16'h8002, 16'h0033, 16'h0044,
                     16'hFFFF, 16'h2000, 16'hABCD, 16'h01FE, 16'h7F00, 16'h4242,
                     16'h0099, 16'h00AA, 16'hFFFE, 16'h0000};

  int m_ph = 0, m_kind = 0, m_addr = 0, m_wd = 0;
  bit started = 0;
  logic ev_valid = 1'b0;
  logic [7:0] ev_data = 8'h00;

  always @(posedge clk) begin
    if (started) begin
      if ((is_fetch(m_kind) && (m_ph == 5 || m_ph == 11)) || (is_rd(m_kind) && m_ph == 11)) begin
        ev_valid = 1'b1;
        ev_data  = p0_in;
      end else begin
        ev_valid = 1'b0;
      end
      if (m_ph == 11) begin
        m_ph = 0; m_kind = int'(req_kind); m_addr = int'(req_addr); m_wd = int'(req_wdata);
      end else begin
        m_ph++;
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  int cnt = 0, mc = 0, ridx = 0;
  int n_ale = 0, n_psen = 0, n_strb = 0;
  logic pa = 1'b0, pp = 1'b1, pr = 1'b1, pw = 1'b1;

  always @(negedge clk) begin
    logic e_ale, e_psen, e_rd, e_wr, e_oe, addr_ph, dphase;
    logic [7:0] e_p0, e_p2;
    int a;
    cnt++;
    if (cnt <= 3) begin
      chk("R1 ale in reset", ale, 0);
      chk("R1 psen_n in reset", psen_n, 1);
      chk("R1 rd_n/wr_n in reset", {rd_n, wr_n}, 2'b11);
      chk("R1 p0_oe in reset", p0_oe, 0);
      chk("R1 p2_out in reset", p2_out, 0);
      chk("R1 rd_valid in reset", rd_valid, 0);
    end else begin
      if (cnt == 4) begin
        rst_n = 1'b1;
        m_ph = 0; m_kind = 0; m_addr = 0; m_wd = 0;
        started = 1;
        #1;
        chk("R1 first cycle fetches 0000H", {p2_out, p0_out}, 16'h0000);
      end
      dphase  = !is_fetch(m_kind);
      a       = (is_fetch(m_kind) && m_ph >= 6) ? ((m_addr + 1) & 16'hFFFF) : m_addr;
      addr_ph = (m_ph <= 2) || (is_fetch(m_kind) && m_ph >= 6 && m_ph <= 8);
      e_ale   = (m_ph <= 1) || (is_fetch(m_kind) && (m_ph == 6 || m_ph == 7));
      e_psen  = !(is_fetch(m_kind) && ((m_ph >= 3 && m_ph <= 5) || m_ph >= 9));
      e_rd    = !(is_rd(m_kind) && m_ph >= 3);
      e_wr    = !(is_wr(m_kind) && m_ph >= 3);
      e_oe    = addr_ph || (is_wr(m_kind) && m_ph >= 3);
      e_p0    = addr_ph ? a[7:0] : (is_wr(m_kind) && m_ph >= 3) ? m_wd[7:0] : 8'h00;
      e_p2    = is_8(m_kind) ? p2_latch : a[15:8];

      chk("R2 cyc_last", cyc_last, (m_ph == 11));
      chk("R3 ale level", ale, e_ale);
      chk("R4 psen_n level", psen_n, e_psen);
      chk("R5 rd_n level", rd_n, e_rd);
      chk("R5 wr_n level", wr_n, e_wr);
      chk("R6 p0_oe", p0_oe, e_oe);
      if (dphase && addr_ph) chk("R10 data low address", p0_out, e_p0);
      else                   chk("R6 p0_out", p0_out, e_p0);
      if (dphase && !is_8(m_kind)) chk("R10 data high address", p2_out, e_p2);
      else                         chk("R7 p2_out", p2_out, e_p2);
      chk("R8 rd_valid", rd_valid, ev_valid);
      if (ev_valid) chk("R8 rd_data", rd_data, ev_data);

      if (m_ph == 0) begin n_ale = 0; n_psen = 0; n_strb = 0; end
      if (ale && !pa) n_ale++;
      if (!psen_n && pp) n_psen++;
      if ((!rd_n && pr) || (!wr_n && pw)) n_strb++;
      pa = ale; pp = psen_n; pr = rd_n; pw = wr_n;

      if (m_ph == 11) begin
        chk("R3 ale pulses per cycle", n_ale, is_fetch(m_kind) ? 2 : 1);
        chk("R4 psen_n pulses per cycle", n_psen, is_fetch(m_kind) ? 2 : 0);
        chk("R5 data strobe pulses per cycle", n_strb, is_fetch(m_kind) ? 0 : 1);
        if (m_kind >= 5) chk("R9 undefined code acts as fetch", n_psen, 2);
        mc++;
        req_kind  = 3'(kinds[ridx]);
        req_addr  = 16'(addrs[ridx]);
        req_wdata = 8'(8'h5A ^ ridx);
        ridx = (ridx + 1) % 16;
      end
      if (mc == 40) finish_run();
    end
    p0_in    = 8'(cnt * 7 + 3);
    p2_latch = 8'(8'hC0 + cnt);
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule